// File: doc/BRIEF.md
# Single-Precision Floating-Point Add/Subtract Unit

The unit adds or subtracts two single-precision operands that arrive already split into sign, biased exponent and 23-bit fraction fields. The fraction is taken to carry an implicit leading one, so every operand is treated as a normalised number. The result comes back in the same three fields. The unit has no rounding stage and no guard bits, and it gives no special treatment to infinities, NaNs or denormals. Exponent arithmetic wraps modulo the exponent width, and nothing traps an overflow or an underflow.

A one-cycle `start` strobe, given while the unit is idle, captures the operands and the `op_sub` selector. The work passes through three named states:

- `ST_IDLE` waits for `start` and captures the operands. It moves to `ST_ALIGN` on `start` and stays in `ST_IDLE` otherwise.
- `ST_ALIGN` aligns the mantissas and performs the signed mantissa add or subtract. It always moves to `ST_NORM`.
- `ST_NORM` normalises the result, updates the outputs and pulses `done`. It always returns to `ST_IDLE`.

The result and `done` therefore appear exactly two clock edges after the edge that accepted `start`. The outputs then hold their value until the next result replaces them.

Top module: `fpas_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `done` is 0 and the result fields `r_sign`, `r_exp` and `r_frac` are all zero.
- R2: When `start` is high at a rising edge while the unit is idle, the operands are captured at that edge. `done` is high for exactly one cycle, after the second rising edge that follows.
- R3: A `start` that is high at either of the two edges after an accepted start is ignored. It produces no extra `done` pulse and does not change the result.
- R4: Between `done` pulses, `r_sign`, `r_exp` and `r_frac` keep their value.
- R5: With `op_sub` = 1 the unit computes a minus b by inverting b's sign and then adding. With `op_sub` = 0 it computes a plus b.
- R6: The mantissa (1.fraction) of the operand with the smaller exponent is shifted right by the exponent difference. Shifted-out bits are discarded. A difference of 24 or more leaves that operand contributing zero. The larger exponent becomes the working exponent.
- R7: When the effective signs are equal, the aligned mantissas are added and the result sign is a's sign. A carry out of the 24-bit sum shifts the mantissa right by one, dropping the lowest bit, and increments the exponent. For example, 0x3F800000 + 0x3F800000 gives 0x40000000.
- R8: When the effective signs differ, the smaller aligned mantissa is subtracted from the larger one, and the result takes the sign of the larger. With equal aligned mantissas, a's sign is used.
- R9: A non-zero difference is shifted left until its bit 23 is 1, and the exponent is decreased by the shift count, modulo 256. For example, 0x3F800000 − 0x3F7FFFFF gives 0x34000000.
- R10: When the aligned mantissa difference is exactly zero, the result is all zero: sign 0, exponent 0 and fraction 0.
- R11: 0x18360000 + 0x1C120000 gives 0x1C12B600, and 0x18360000 − 0x1C120000 gives 0x9C114A00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches an operation when the unit is idle |
| op_sub | input | 1 | 1 selects a − b, 0 selects a + b |
| a_sign | input | 1 | Sign of operand a |
| a_exp | input | 8 | Biased exponent of operand a |
| a_frac | input | 23 | Fraction of operand a (implicit leading one) |
| b_sign | input | 1 | Sign of operand b |
| b_exp | input | 8 | Biased exponent of operand b |
| b_frac | input | 23 | Fraction of operand b (implicit leading one) |
| done | output | 1 | One-cycle pulse when a new result is on the outputs |
| r_sign | output | 1 | Result sign |
| r_exp | output | 8 | Result biased exponent |
| r_frac | output | 23 | Result fraction |

## Verification
Directed pairs separate the arithmetic paths:

- Equal signs with a carry test the right-shift path.
- Equal exponents with opposite signs, where b is the larger, test the choice of result sign.
- Near-equal operands test a deep left normalisation.
- Identical operands test exact cancellation.
- Exponent gaps of 23 and 24, and a truncated half bit, test alignment at the edge of the mantissa.
- The two stated example pairs fix the exact bit patterns.

A stream of pseudo-random operands, with exponents close to each other, then mixes every path against a behavioural model. A burst of three back-to-back starts shows that only the first one is taken.

// File: rtl/fpas_pkg.sv
package fpas_pkg;

    // Sequencing states of the add/subtract unit
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_NORM  = 2'd2
    } fpas_state_t;

    // Effective mantissa operation chosen from the signs
    typedef enum logic {
        MOP_ADD = 1'b0,
        MOP_SUB = 1'b1
    } fpas_mop_t;

endpackage

// File: rtl/fpas_align.sv
module fpas_align #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 24
) (
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_b,
    input  logic [MAN_W-1:0] man_a,
    input  logic [MAN_W-1:0] man_b,
    output logic [EXP_W-1:0] exp_big,
    output logic [MAN_W-1:0] al_a,
    output logic [MAN_W-1:0] al_b
);
    localparam int SH_W = $clog2(MAN_W + 1);

    logic             a_wins;
    logic [EXP_W-1:0] gap;
    logic             too_far;
    logic [MAN_W-1:0] small_in;
    logic [MAN_W-1:0] stg [0:SH_W];

    assign a_wins   = (exp_a >= exp_b);
    assign gap      = a_wins ? (exp_a - exp_b) : (exp_b - exp_a);
    assign too_far  = (int'(gap) >= MAN_W);
    assign small_in = a_wins ? man_b : man_a;
    assign exp_big  = a_wins ? exp_a : exp_b;

    // Logarithmic right shifter, one stage per bit of the shift amount
    assign stg[0] = small_in;
    for (genvar k = 0; k < SH_W; k++) begin : g_shift
        assign stg[k+1] = gap[k] ? (stg[k] >> (1 << k)) : stg[k];
    end

    logic [MAN_W-1:0] small_out;
    assign small_out = too_far ? '0 : stg[SH_W];

    assign al_a = a_wins ? man_a : small_out;
    assign al_b = a_wins ? small_out : man_b;

endmodule

// File: rtl/fpas_mantop.sv
module fpas_mantop
    import fpas_pkg::*;
#(
    parameter int MAN_W = 24
) (
    input  logic [MAN_W-1:0] al_a,
    input  logic [MAN_W-1:0] al_b,
    input  logic             sign_a,
    input  logic             sign_b,
    output logic [MAN_W:0]   raw,
    output logic             res_sign
);
    fpas_mop_t mop;
    logic      a_ge;

    always_comb begin
        mop  = (sign_a ~^ sign_b) ? MOP_ADD : MOP_SUB;
        a_ge = (al_a >= al_b);
        unique case (mop)
            MOP_ADD: begin
                raw      = {1'b0, al_a} + {1'b0, al_b};
                res_sign = sign_a;
            end
            MOP_SUB: begin
                if (a_ge) begin
                    raw      = {1'b0, al_a} - {1'b0, al_b};
                    res_sign = sign_a;
                end else begin
                    raw      = {1'b0, al_b} - {1'b0, al_a};
                    res_sign = sign_b;
                end
            end
            default: begin
                raw      = '0;
                res_sign = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fpas_norm.sv
module fpas_norm #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 24
) (
    input  logic [MAN_W:0]   raw,
    input  logic [EXP_W-1:0] exp_big,
    output logic [MAN_W-2:0] frac_n,
    output logic [EXP_W-1:0] exp_n,
    output logic             is_zero
);
    localparam int LZ_W = $clog2(MAN_W + 1);

    logic [LZ_W-1:0] lz;
    logic            seen;

    // Count leading zeros of the 24-bit field below the carry bit
    always_comb begin
        lz   = '0;
        seen = 1'b0;
        for (int i = MAN_W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (raw[i]) seen = 1'b1;
                else        lz   = lz + 1'b1;
            end
        end
    end

    assign is_zero = (raw == '0);

    always_comb begin
        if (raw[MAN_W]) begin
            frac_n = raw[MAN_W-1:1];
            exp_n  = exp_big + 1'b1;
        end else if (is_zero) begin
            frac_n = '0;
            exp_n  = '0;
        end else begin
            // The bit that lands on the hidden position is dropped either way
            frac_n = raw[MAN_W-2:0] << lz;
            exp_n  = exp_big - EXP_W'(lz);
        end
    end

endmodule

// File: rtl/fpas_core.sv
module fpas_core
    import fpas_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_sub,
    input  logic              a_sign,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [FRAC_W-1:0] a_frac,
    input  logic              b_sign,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [FRAC_W-1:0] b_frac,
    output logic              done,
    output logic              r_sign,
    output logic [EXP_W-1:0]  r_exp,
    output logic [FRAC_W-1:0] r_frac
);
    localparam int MAN_W = FRAC_W + 1;

    fpas_state_t state, state_nx;

    // Captured operands
    logic             s_a_sign, s_b_sign;
    logic [EXP_W-1:0] s_a_exp, s_b_exp;
    logic [MAN_W-1:0] s_a_man, s_b_man;

    // Mantissa result stage
    logic [MAN_W:0]   raw_q;
    logic [EXP_W-1:0] ebig_q;
    logic             sgn_q;

    // Combinational datapath
    logic [EXP_W-1:0] exp_big_c;
    logic [MAN_W-1:0] al_a_c, al_b_c;
    logic [MAN_W:0]   raw_c;
    logic             sign_c;
    logic [FRAC_W-1:0] frac_n_c;
    logic [EXP_W-1:0] exp_n_c;
    logic             zero_c;

    fpas_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
        .exp_a   (s_a_exp),
        .exp_b   (s_b_exp),
        .man_a   (s_a_man),
        .man_b   (s_b_man),
        .exp_big (exp_big_c),
        .al_a    (al_a_c),
        .al_b    (al_b_c)
    );

    fpas_mantop #(.MAN_W(MAN_W)) u_mantop (
        .al_a     (al_a_c),
        .al_b     (al_b_c),
        .sign_a   (s_a_sign),
        .sign_b   (s_b_sign),
        .raw      (raw_c),
        .res_sign (sign_c)
    );

    fpas_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
        .raw     (raw_q),
        .exp_big (ebig_q),
        .frac_n  (frac_n_c),
        .exp_n   (exp_n_c),
        .is_zero (zero_c)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_ALIGN;
            ST_ALIGN: state_nx = ST_NORM;
            ST_NORM:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            s_a_sign <= 1'b0;
            s_b_sign <= 1'b0;
            s_a_exp  <= '0;
            s_b_exp  <= '0;
            s_a_man  <= '0;
            s_b_man  <= '0;
            raw_q    <= '0;
            ebig_q   <= '0;
            sgn_q    <= 1'b0;
            done     <= 1'b0;
            r_sign   <= 1'b0;
            r_exp    <= '0;
            r_frac   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        s_a_sign <= a_sign;
                        s_b_sign <= b_sign ^ op_sub;
                        s_a_exp  <= a_exp;
                        s_b_exp  <= b_exp;
                        s_a_man  <= {1'b1, a_frac};
                        s_b_man  <= {1'b1, b_frac};
                    end
                end
                ST_ALIGN: begin
                    raw_q  <= raw_c;
                    ebig_q <= exp_big_c;
                    sgn_q  <= sign_c;
                end
                ST_NORM: begin
                    r_sign <= zero_c ? 1'b0 : sgn_q;
                    r_exp  <= exp_n_c;
                    r_frac <= frac_n_c;
                    done   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fpas_checker.sv
module fpas_checker #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              op_sub,
    input logic              a_sign,
    input logic [EXP_W-1:0]  a_exp,
    input logic [FRAC_W-1:0] a_frac,
    input logic              b_sign,
    input logic [EXP_W-1:0]  b_exp,
    input logic [FRAC_W-1:0] b_frac,
    input logic              done,
    input logic              r_sign,
    input logic [EXP_W-1:0]  r_exp,
    input logic [FRAC_W-1:0] r_frac
);
    logic [1:0]        pend;
    logic              accept;
    logic              c_same, c_twin, c_cancel, c_a_sign;
    logic [EXP_W-1:0]  c_a_exp;
    logic [FRAC_W-1:0] c_a_frac;
    logic              eq_mag, eff_same;

    assign accept   = start && (pend == 2'd0);
    assign eq_mag   = (a_exp == b_exp) && (a_frac == b_frac);
    assign eff_same = (a_sign == (b_sign ^ op_sub));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 2'd0;
            c_same   <= 1'b0;
            c_twin   <= 1'b0;
            c_cancel <= 1'b0;
            c_a_sign <= 1'b0;
            c_a_exp  <= '0;
            c_a_frac <= '0;
        end else if (accept) begin
            pend     <= 2'd2;
            c_same   <= eff_same;
            c_twin   <= eff_same && eq_mag;
            c_cancel <= !eff_same && eq_mag;
            c_a_sign <= a_sign;
            c_a_exp  <= a_exp;
            c_a_frac <= a_frac;
        end else if (pend != 2'd0) begin
            pend <= pend - 2'd1;
        end
    end

    AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (rst)
        (pend == 2'd1) |=> done);  // R2

    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (rst)
        (pend != 2'd1) |=> !done);  // R3

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({r_sign, r_exp, r_frac}));  // R4

    AST_SAME_SIGN: assert property (@(posedge clk) disable iff (rst)
        (done && c_same) |-> (r_sign == c_a_sign));  // R7

    AST_TWIN_CARRY: assert property (@(posedge clk) disable iff (rst)
        (done && c_twin) |-> (r_exp == EXP_W'(c_a_exp + 1'b1) && r_frac == c_a_frac));  // R7

    AST_CANCEL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && c_cancel) |-> ({r_sign, r_exp, r_frac} == '0));  // R10

endmodule

bind fpas_core fpas_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op_sub (op_sub),
    .a_sign (a_sign),
    .a_exp  (a_exp),
    .a_frac (a_frac),
    .b_sign (b_sign),
    .b_exp  (b_exp),
    .b_frac (b_frac),
    .done   (done),
    .r_sign (r_sign),
    .r_exp  (r_exp),
    .r_frac (r_frac)
);

// File: tb/fpas_core_tb_top.sv
`timescale 1ns/1ps
module fpas_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_sub = 1'b0;
    logic [31:0] a_w = '0;
    logic [31:0] b_w = '0;
    logic        done;
    logic        r_sign;
    logic [7:0]  r_exp;
    logic [22:0] r_frac;
    logic [31:0] res;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit wd_fired = 1'b0;

    always #10 clk = ~clk;

    fpas_core dut_i (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .op_sub (op_sub),
        .a_sign (a_w[31]),
        .a_exp  (a_w[30:23]),
        .a_frac (a_w[22:0]),
        .b_sign (b_w[31]),
        .b_exp  (b_w[30:23]),
        .b_frac (b_w[22:0]),
        .done   (done),
        .r_sign (r_sign),
        .r_exp  (r_exp),
        .r_frac (r_frac)
    );

    assign res = {r_sign, r_exp, r_frac};

    // Behavioural reference for one operation
    function automatic logic [31:0] ref_addsub(input logic [31:0] a, input logic [31:0] b,
                                               input logic sub);
        int      ea, eb, eg, d;
        longint  ma, mb, m;
        logic    sa, sb, s;
        sa = a[31];
        sb = b[31] ^ sub;
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        ma = longint'({1'b1, a[22:0]});
        mb = longint'({1'b1, b[22:0]});
        if (ea >= eb) begin
            eg = ea; d = ea - eb;
            mb = (d >= 24) ? 0 : (mb >> d);
        end else begin
            eg = eb; d = eb - ea;
            ma = (d >= 24) ? 0 : (ma >> d);
        end
        if (sa == sb)      begin m = ma + mb; s = sa; end
        else if (ma >= mb) begin m = ma - mb; s = sa; end
        else               begin m = mb - ma; s = sb; end
        if (m == 0) return 32'h0;
        if (m >= 64'd16777216) begin m = m / 2; eg = eg + 1; end
        while (m < 64'd8388608) begin m = m * 2; eg = eg - 1; end
        return {s, eg[7:0], m[22:0]};
    endfunction

    // Cycle model: updated at each rising edge from the held inputs
    int          mdl_pend = 0;
    logic        mdl_done = 1'b0;
    logic [31:0] mdl_res  = '0;
    logic [31:0] mdl_next = '0;

    always @(posedge clk) begin
        if (rst) begin
            mdl_pend = 0;
            mdl_done = 1'b0;
            mdl_res  = '0;
        end else begin
            mdl_done = 1'b0;
            if (mdl_pend == 1) begin
                mdl_done = 1'b1;
                mdl_res  = mdl_next;
            end
            if (mdl_pend > 0) begin
                mdl_pend = mdl_pend - 1;
            end else if (start) begin
                mdl_pend = 2;
                mdl_next = ref_addsub(a_w, b_w, op_sub);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !wd_fired) begin
            chk("R2 done timing", {31'b0, done}, {31'b0, mdl_done});
            chk("R9 result vs model", res, mdl_res);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !wd_fired) begin
            wd_fired = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual %0d cycles expected below 60000", cyc);
            finish_run();
        end
    end

    // Launch one operation and check the result in the done cycle
    task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic sub,
                         input logic [31:0] exp, input string req);
        @(negedge clk);
        a_w = a; b_w = b; op_sub = sub; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk({req, " done early"}, {31'b0, done}, 32'd0);
        @(negedge clk);
        chk({req, " done"}, {31'b0, done}, 32'd1);
        chk(req, res, exp);
        @(negedge clk);
        chk({req, " done pulse"}, {31'b0, done}, 32'd0);
    endtask

    logic [31:0] rng = 32'h1234_5679;
    function automatic logic [31:0] step(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset result", res, 32'h0);
        chk("R1 reset done", {31'b0, done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset result", res, 32'h0);
        chk("R1 after reset done", {31'b0, done}, 32'd0);

        do_op(32'h18360000, 32'h1C120000, 1'b0, 32'h1C12B600, "R11 sum example");
        do_op(32'h18360000, 32'h1C120000, 1'b1, 32'h9C114A00, "R11 R5 difference example");
        do_op(32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, "R7 carry 1+1");
        do_op(32'h3FC00000, 32'h3FE00000, 1'b0, 32'h40500000, "R7 carry 1.5+1.75");
        do_op(32'h3FC00000, 32'h3FE00000, 1'b1, 32'hBE800000, "R8 R5 b larger");
        do_op(32'hBFE00000, 32'h3FC00000, 1'b0, 32'hBE800000, "R8 a larger negative");
        do_op(32'h3F800000, 32'h3F7FFFFF, 1'b1, 32'h34000000, "R9 deep normalise");
        do_op(32'h3FC00000, 32'h3FC00000, 1'b1, 32'h00000000, "R10 cancel");
        do_op(32'hC0400000, 32'h40400000, 1'b0, 32'h00000000, "R10 cancel opposite signs");
        do_op(32'h4B000000, 32'h3F800000, 1'b0, 32'h4B000001, "R6 gap 23");
        do_op(32'h4B800000, 32'h3F800000, 1'b0, 32'h4B800000, "R6 gap 24");
        do_op(32'h4B000000, 32'h3FC00000, 1'b0, 32'h4B000001, "R6 truncation");
        do_op(32'h3F800000, 32'h4B000000, 1'b1, 32'hCAFFFFFE, "R6 R5 a smaller");

        // R3: start held for three cycles with different operands
        @(negedge clk);
        a_w = 32'h18360000; b_w = 32'h1C120000; op_sub = 1'b0; start = 1'b1;
        @(negedge clk);
        a_w = 32'h3F800000; b_w = 32'h3F800000;
        @(negedge clk);
        a_w = 32'h40000000; b_w = 32'h3F800000; op_sub = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R3 busy first result", res, 32'h1C12B600);
        chk("R3 busy done", {31'b0, done}, 32'd1);
        repeat (3) begin
            @(negedge clk);
            chk("R3 no extra done", {31'b0, done}, 32'd0);
            chk("R4 result held", res, 32'h1C12B600);
        end

        // Pseudo-random mix with exponents close together
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            logic        sub;
            int          ea, eb;
            rng = step(rng); a = rng;
            rng = step(rng); b = rng;
            ea = 30 + int'(a[30:23] % 190);
            eb = ea + int'(b[27:23]) - 16;
            a[30:23] = ea[7:0];
            b[30:23] = eb[7:0];
            if (b[31:28] == 4'h0) b[30:0] = a[30:0];
            rng = step(rng); sub = rng[3];
            do_op(a, b, sub, ref_addsub(a, b, sub), "R9 random");
        end

        finish_run();
    end

endmodule